// File: doc/BRIEF.md
# Group Issue Interlock

This block sits at the issue stage of an in-order core that dispatches instructions in explicit groups, where a stop bit closes each group. Each cycle, a chunk of up to `LANES` instructions from the current group is presented. For every lane the block receives two general-register sources, one general-register destination, a predicate source, a predicate destination, an enable for each of these fields, a class flag (integer or floating point) and a branch flag. It answers with a single `issue_en` in the same cycle. When `issue_en` is low, the whole chunk is held. Upstream keeps the chunk on its inputs until `issue_en` is high.

Two scoreboards track pending results, one for the 64 general registers and one for the 64 predicate registers. Each entry holds a countdown. When an instruction issues, the countdown of its destination is loaded with the producer's latency: `INT_LAT` for integer work with forwarding, `NOFWD_LAT` when `FORWARD` is cleared, and `FP_LAT` for floating point. After that the countdown falls by one each cycle. A register is ready once its countdown is 1 or less.

Entries written by a group that is still open (no stop issued yet) count as ready to later chunks of the same group, because the members of one group are declared independent. A branch may read a predicate that a compare in the same chunk produces without waiting.

Top module: `group_interlock`

## Requirements
- R1: After reset, every scoreboard entry is idle, so any chunk issues in the cycle it is presented, whatever registers it names.
- R2: With `FORWARD`=1, an integer producer's result can be read by a consumer in a later group one cycle after the producer issues, so a chain of dependent integer instructions issues one per cycle.
- R3: A consumer of a floating-point result issues no earlier than `FP_LAT` (4) cycles after its producer issues, so a dependent floating-point chain issues one per four cycles.
- R4: With `FORWARD`=0, an integer result is held for `NOFWD_LAT` (4) cycles, the same as floating point.
- R5: A register written by a chunk issued without its stop bit is not a hazard for later chunks of the same group. Once a chunk issues with its stop bit set, that register's remaining countdown applies to the next group.
- R6: A lane with its branch flag set does not wait on its predicate source when another valid lane in the same chunk writes that predicate. A lane without the branch flag, or a branch with no such compare beside it, waits on the predicate scoreboard.
- R7: A general-register destination whose previous result is still pending (countdown above 1) holds the chunk.
- R8: The chunk is held if any valid lane is blocked. Fields of a lane whose valid bit is 0 have no effect. Lane i is bit i of every per-lane bus.
- R9: `issue_en` is combinational in the presented chunk and is never high while `grp_valid` is low.
- R10: A source or destination field whose enable bit is 0 is ignored, for both general and predicate registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| grp_valid | input | 1 | A chunk is presented this cycle |
| grp_stop | input | 1 | This chunk ends its group |
| ln_valid | input | LANES | Lane holds an instruction |
| ln_fp | input | LANES | Lane is a floating-point producer |
| ln_branch | input | LANES | Lane is a branch reading its predicate source |
| ln_sa_en | input | LANES | First general source used |
| ln_sb_en | input | LANES | Second general source used |
| ln_dst_en | input | LANES | General destination written |
| ln_psrc_en | input | LANES | Predicate source used |
| ln_pdst_en | input | LANES | Predicate destination written |
| ln_sa | input | LANES x 6 | First general source number |
| ln_sb | input | LANES x 6 | Second general source number |
| ln_dst | input | LANES x 6 | General destination number |
| ln_psrc | input | LANES x 6 | Predicate source number |
| ln_pdst | input | LANES x 6 | Predicate destination number |
| issue_en | output | 1 | The presented chunk issues at the next clock edge |

## Verification
The hardest behaviour to reach is the interplay of open groups with pending countdowns. A register must be bypassed while its group is open and then fall back under its remaining countdown as soon as the group closes. The stimulus reaches this by issuing a floating-point write without a stop, reading the same register in the closing chunk, and reading it again in the following group, where the wait must equal the remaining countdown. The compare-to-branch exemption is isolated the same way. A floating-point compare first leaves its predicate pending. The next chunk is then built three ways: with the branch flag set, with the flag cleared, and without the compare.

// File: rtl/gil_pkg.sv
package gil_pkg;

  typedef enum logic {
    CLS_INT = 1'b0,
    CLS_FP  = 1'b1
  } op_class_e;

  // Countdown loaded into a destination entry when its producer issues.
  function automatic int unsigned pick_lat(
    input logic        is_fp,
    input int unsigned int_lat,
    input int unsigned fp_lat,
    input int unsigned nofwd_lat,
    input bit          forward
  );
    if (is_fp == CLS_FP) return fp_lat;
    else if (forward)    return int_lat;
    else                 return nofwd_lat;
  endfunction

  function automatic int unsigned max3(
    input int unsigned a,
    input int unsigned b,
    input int unsigned c
  );
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/gil_rst_sync.sv
module gil_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/gil_score_bank.sv
module gil_score_bank #(
  parameter int unsigned IDX_W = 6,
  parameter int unsigned CW    = 3,
  parameter int unsigned NW    = 2,
  parameter int unsigned NR    = 6
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      issue,
  input  logic                      close,
  input  logic [NW-1:0]             wr_en,
  input  logic [NW-1:0][IDX_W-1:0]  wr_idx,
  input  logic [NW-1:0][CW-1:0]     wr_lat,
  input  logic [NR-1:0][IDX_W-1:0]  rd_idx,
  output logic [NR-1:0]             rd_busy
);

  localparam int unsigned NENT = 1 << IDX_W;

  logic [CW-1:0]   cnt_q [NENT];
  logic [CW-1:0]   cnt_d [NENT];
  logic [NENT-1:0] open_q;
  logic [NENT-1:0] open_d;
  logic [NENT-1:0] ent_en;

  // Next state: decay every live entry, clear open marks on a closing
  // issue, and load the issuing writers (highest lane wins).
  always_comb begin
    for (int e = 0; e < NENT; e++) begin
      cnt_d[e]  = (cnt_q[e] != '0) ? cnt_q[e] - CW'(1) : '0;
      open_d[e] = open_q[e] & ~close;
      if (issue) begin
        for (int w = 0; w < NW; w++) begin
          if (wr_en[w] && (wr_idx[w] == IDX_W'(e))) begin
            cnt_d[e]  = wr_lat[w];
            open_d[e] = ~close;
          end
        end
      end
      ent_en[e] = issue | (cnt_q[e] != '0) | open_q[e];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int e = 0; e < NENT; e++) cnt_q[e] <= '0;
      open_q <= '0;
    end else begin
      for (int e = 0; e < NENT; e++) begin
        if (ent_en[e]) begin
          cnt_q[e]  <= cnt_d[e];
          open_q[e] <= open_d[e];
        end
      end
    end
  end

  generate
    for (genvar r = 0; r < NR; r++) begin : g_rd
      assign rd_busy[r] = (cnt_q[rd_idx[r]] > CW'(1)) && !open_q[rd_idx[r]];
    end
  endgenerate

endmodule

// File: rtl/gil_lane_check.sv
module gil_lane_check #(
  parameter int unsigned LANES = 2,
  parameter int unsigned PW    = 6
) (
  input  logic [LANES-1:0]          ln_valid,
  input  logic [LANES-1:0]          ln_branch,
  input  logic [LANES-1:0]          ln_sa_en,
  input  logic [LANES-1:0]          ln_sb_en,
  input  logic [LANES-1:0]          ln_dst_en,
  input  logic [LANES-1:0]          ln_psrc_en,
  input  logic [LANES-1:0]          ln_pdst_en,
  input  logic [LANES-1:0][PW-1:0]  ln_psrc,
  input  logic [LANES-1:0][PW-1:0]  ln_pdst,
  input  logic [3*LANES-1:0]        gpr_busy,
  input  logic [LANES-1:0]          prd_busy,
  output logic [LANES-1:0]          lane_block
);

  logic [LANES-1:0] pred_local;

  always_comb begin
    for (int i = 0; i < LANES; i++) begin
      pred_local[i] = 1'b0;
      for (int j = 0; j < LANES; j++) begin
        if ((j != i) && ln_valid[j] && ln_pdst_en[j] &&
            (ln_pdst[j] == ln_psrc[i]))
          pred_local[i] = 1'b1;
      end
      lane_block[i] = ln_valid[i] &
                      ((ln_sa_en[i]  & gpr_busy[3*i])   |
                       (ln_sb_en[i]  & gpr_busy[3*i+1]) |
                       (ln_dst_en[i] & gpr_busy[3*i+2]) |
                       (ln_psrc_en[i] & prd_busy[i] &
                        ~(ln_branch[i] & pred_local[i])));
    end
  end

endmodule

// File: rtl/group_interlock.sv
module group_interlock
  import gil_pkg::*;
#(
  parameter int unsigned LANES     = 2,
  parameter int unsigned GPR_IDX_W = 6,
  parameter int unsigned PRD_IDX_W = 6,
  parameter int unsigned INT_LAT   = 1,
  parameter int unsigned FP_LAT    = 4,
  parameter int unsigned NOFWD_LAT = 4,
  parameter bit          FORWARD   = 1'b1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          grp_valid,
  input  logic                          grp_stop,
  input  logic [LANES-1:0]              ln_valid,
  input  logic [LANES-1:0]              ln_fp,
  input  logic [LANES-1:0]              ln_branch,
  input  logic [LANES-1:0]              ln_sa_en,
  input  logic [LANES-1:0]              ln_sb_en,
  input  logic [LANES-1:0]              ln_dst_en,
  input  logic [LANES-1:0]              ln_psrc_en,
  input  logic [LANES-1:0]              ln_pdst_en,
  input  logic [LANES-1:0][GPR_IDX_W-1:0] ln_sa,
  input  logic [LANES-1:0][GPR_IDX_W-1:0] ln_sb,
  input  logic [LANES-1:0][GPR_IDX_W-1:0] ln_dst,
  input  logic [LANES-1:0][PRD_IDX_W-1:0] ln_psrc,
  input  logic [LANES-1:0][PRD_IDX_W-1:0] ln_pdst,
  output logic                          issue_en
);

  localparam int unsigned MAXLAT = max3(INT_LAT, FP_LAT, NOFWD_LAT);
  localparam int unsigned CW     = $clog2(MAXLAT + 1);
  localparam int unsigned NGR    = 3 * LANES;

  logic                              rst_sync_n;
  logic [LANES-1:0][CW-1:0]          lane_lat;
  logic [LANES-1:0]                  gpr_wr;
  logic [LANES-1:0]                  prd_wr;
  logic [NGR-1:0][GPR_IDX_W-1:0]     gpr_rd_idx;
  logic [NGR-1:0]                    gpr_busy;
  logic [LANES-1:0]                  prd_busy;
  logic [LANES-1:0]                  lane_block;
  logic                              grp_close;

  gil_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  generate
    for (genvar i = 0; i < LANES; i++) begin : g_lane
      assign lane_lat[i] = CW'(pick_lat(ln_fp[i], INT_LAT, FP_LAT,
                                        NOFWD_LAT, FORWARD));
      assign gpr_wr[i]   = ln_valid[i] & ln_dst_en[i];
      assign prd_wr[i]   = ln_valid[i] & ln_pdst_en[i];
      assign gpr_rd_idx[3*i]   = ln_sa[i];
      assign gpr_rd_idx[3*i+1] = ln_sb[i];
      assign gpr_rd_idx[3*i+2] = ln_dst[i];
    end
  endgenerate

  assign issue_en  = grp_valid & ~(|lane_block);
  assign grp_close = issue_en & grp_stop;

  gil_score_bank #(
    .IDX_W (GPR_IDX_W),
    .CW    (CW),
    .NW    (LANES),
    .NR    (NGR)
  ) u_gpr (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .issue   (issue_en),
    .close   (grp_close),
    .wr_en   (gpr_wr),
    .wr_idx  (ln_dst),
    .wr_lat  (lane_lat),
    .rd_idx  (gpr_rd_idx),
    .rd_busy (gpr_busy)
  );

  gil_score_bank #(
    .IDX_W (PRD_IDX_W),
    .CW    (CW),
    .NW    (LANES),
    .NR    (LANES)
  ) u_prd (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .issue   (issue_en),
    .close   (grp_close),
    .wr_en   (prd_wr),
    .wr_idx  (ln_pdst),
    .wr_lat  (lane_lat),
    .rd_idx  (ln_psrc),
    .rd_busy (prd_busy)
  );

  gil_lane_check #(
    .LANES (LANES),
    .PW    (PRD_IDX_W)
  ) u_check (
    .ln_valid   (ln_valid),
    .ln_branch  (ln_branch),
    .ln_sa_en   (ln_sa_en),
    .ln_sb_en   (ln_sb_en),
    .ln_dst_en  (ln_dst_en),
    .ln_psrc_en (ln_psrc_en),
    .ln_pdst_en (ln_pdst_en),
    .ln_psrc    (ln_psrc),
    .ln_pdst    (ln_pdst),
    .gpr_busy   (gpr_busy),
    .prd_busy   (prd_busy),
    .lane_block (lane_block)
  );

endmodule

// File: rtl/gil_checker.sv
module gil_checker #(
  parameter int unsigned LANES     = 2,
  parameter int unsigned GPR_IDX_W = 6,
  parameter int unsigned INT_LAT   = 1,
  parameter int unsigned FP_LAT    = 4,
  parameter bit          FORWARD   = 1'b1
) (
  input logic                           clk,
  input logic                           rst_q,
  input logic                           grp_valid,
  input logic                           grp_stop,
  input logic [LANES-1:0]               ln_valid,
  input logic [LANES-1:0]               ln_fp,
  input logic [LANES-1:0]               ln_sa_en,
  input logic [LANES-1:0]               ln_sb_en,
  input logic [LANES-1:0]               ln_dst_en,
  input logic [LANES-1:0]               ln_psrc_en,
  input logic [LANES-1:0][GPR_IDX_W-1:0] ln_sa,
  input logic [LANES-1:0][GPR_IDX_W-1:0] ln_dst,
  input logic                           issue_en
);

  // R9: no issue without a presented chunk
  assert_issue_needs_valid_R9: assert property (
    @(posedge clk) disable iff (!rst_q) issue_en |-> grp_valid);

  // R5: a register written by an open group never holds a later chunk
  assert_open_group_free_R5: assert property (
    @(posedge clk) disable iff (!rst_q)
    ($past(rst_q && issue_en && !grp_stop && (ln_valid == LANES'(1)) &&
           ln_dst_en[0]) &&
     grp_valid && (ln_valid == LANES'(1)) && ln_sa_en[0] && !ln_sb_en[0] &&
     !ln_dst_en[0] && !ln_psrc_en[0] && (ln_sa[0] == $past(ln_dst[0])))
    |-> issue_en);

  generate
    if (FP_LAT > 1) begin : g_fp
      // R3: a fresh floating-point result is not readable next cycle
      assert_fp_consumer_held_R3: assert property (
        @(posedge clk) disable iff (!rst_q)
        ($past(rst_q && issue_en && grp_stop && (ln_valid == LANES'(1)) &&
               ln_fp[0] && ln_dst_en[0]) &&
         grp_valid && ln_valid[0] && ln_sa_en[0] &&
         (ln_sa[0] == $past(ln_dst[0])))
        |-> !issue_en);

      // R7: rewriting a pending floating-point destination is held
      assert_waw_held_R7: assert property (
        @(posedge clk) disable iff (!rst_q)
        ($past(rst_q && issue_en && grp_stop && (ln_valid == LANES'(1)) &&
               ln_fp[0] && ln_dst_en[0]) &&
         grp_valid && ln_valid[0] && ln_dst_en[0] &&
         (ln_dst[0] == $past(ln_dst[0])))
        |-> !issue_en);
    end

    if (FORWARD && (INT_LAT <= 1)) begin : g_fwd
      // R2: a forwarded integer result is readable the next cycle
      assert_int_forward_free_R2: assert property (
        @(posedge clk) disable iff (!rst_q)
        ($past(rst_q && issue_en && grp_stop && (ln_valid == LANES'(1)) &&
               !ln_fp[0] && ln_dst_en[0]) &&
         grp_valid && (ln_valid == LANES'(1)) && ln_sa_en[0] &&
         !ln_sb_en[0] && !ln_dst_en[0] && !ln_psrc_en[0] &&
         (ln_sa[0] == $past(ln_dst[0])))
        |-> issue_en);
    end
  endgenerate

endmodule

bind group_interlock gil_checker #(
  .LANES     (LANES),
  .GPR_IDX_W (GPR_IDX_W),
  .INT_LAT   (INT_LAT),
  .FP_LAT    (FP_LAT),
  .FORWARD   (FORWARD)
) u_gil_chk (
  .clk        (clk),
  .rst_q      (rst_sync_n),
  .grp_valid  (grp_valid),
  .grp_stop   (grp_stop),
  .ln_valid   (ln_valid),
  .ln_fp      (ln_fp),
  .ln_sa_en   (ln_sa_en),
  .ln_sb_en   (ln_sb_en),
  .ln_dst_en  (ln_dst_en),
  .ln_psrc_en (ln_psrc_en),
  .ln_sa      (ln_sa),
  .ln_dst     (ln_dst),
  .issue_en   (issue_en)
);

// File: tb/group_interlock_tb_top.sv
module group_interlock_tb_top;

  localparam int L  = 2;
  localparam int RW = 6;

  typedef struct packed {
    logic          v;
    logic          fp;
    logic          br;
    logic [RW-1:0] sa;
    logic          sae;
    logic [RW-1:0] sb;
    logic          sbe;
    logic [RW-1:0] d;
    logic          de;
    logic [RW-1:0] ps;
    logic          pse;
    logic [RW-1:0] pd;
    logic          pde;
  } lane_t;

  logic clk = 1'b0;
  logic rst_n;
  logic grp_valid, grp_stop;
  logic [L-1:0] ln_valid, ln_fp, ln_branch, ln_sa_en, ln_sb_en, ln_dst_en;
  logic [L-1:0] ln_psrc_en, ln_pdst_en;
  logic [L-1:0][RW-1:0] ln_sa, ln_sb, ln_dst, ln_psrc, ln_pdst;
  logic issue_fw, issue_nf;

  always #4 clk = ~clk;  // 125 MHz

  group_interlock #(.LANES(L)) dut_i (
    .clk(clk), .rst_n(rst_n), .grp_valid(grp_valid), .grp_stop(grp_stop),
    .ln_valid(ln_valid), .ln_fp(ln_fp), .ln_branch(ln_branch),
    .ln_sa_en(ln_sa_en), .ln_sb_en(ln_sb_en), .ln_dst_en(ln_dst_en),
    .ln_psrc_en(ln_psrc_en), .ln_pdst_en(ln_pdst_en),
    .ln_sa(ln_sa), .ln_sb(ln_sb), .ln_dst(ln_dst),
    .ln_psrc(ln_psrc), .ln_pdst(ln_pdst), .issue_en(issue_fw));

  group_interlock #(.LANES(L), .FORWARD(1'b0)) dut_nf (
    .clk(clk), .rst_n(rst_n), .grp_valid(grp_valid), .grp_stop(grp_stop),
    .ln_valid(ln_valid), .ln_fp(ln_fp), .ln_branch(ln_branch),
    .ln_sa_en(ln_sa_en), .ln_sb_en(ln_sb_en), .ln_dst_en(ln_dst_en),
    .ln_psrc_en(ln_psrc_en), .ln_pdst_en(ln_pdst_en),
    .ln_sa(ln_sa), .ln_sb(ln_sb), .ln_dst(ln_dst),
    .ln_psrc(ln_psrc), .ln_pdst(ln_pdst), .issue_en(issue_nf));

  int    n_vec = 0;
  int    n_bad = 0;
  int    cyc   = 0;
  bit    use_nf = 1'b0;
  int    exp_q[$];
  string tag_q[$];

  function automatic bit cur_issue();
    return use_nf ? issue_nf : issue_fw;
  endfunction

  function automatic lane_t op(bit fp, int src, int dst);
    lane_t l;
    l = '0;
    l.v  = 1'b1;
    l.fp = fp;
    if (src >= 0) begin l.sa = RW'(src); l.sae = 1'b1; end
    if (dst >= 0) begin l.d  = RW'(dst); l.de  = 1'b1; end
    return l;
  endfunction

  task automatic drive(lane_t a, lane_t b, bit stop);
    grp_stop   = stop;
    ln_valid   = {b.v, a.v};     ln_fp      = {b.fp, a.fp};
    ln_branch  = {b.br, a.br};   ln_sa      = {b.sa, a.sa};
    ln_sa_en   = {b.sae, a.sae}; ln_sb      = {b.sb, a.sb};
    ln_sb_en   = {b.sbe, a.sbe}; ln_dst     = {b.d, a.d};
    ln_dst_en  = {b.de, a.de};   ln_psrc    = {b.ps, a.ps};
    ln_psrc_en = {b.pse, a.pse}; ln_pdst    = {b.pd, a.pd};
    ln_pdst_en = {b.pde, a.pde};
  endtask

  // Driver: queue the expected stall count, present the chunk, hold it
  // until the selected instance accepts it.
  task automatic apply(lane_t a, lane_t b, bit stop, int exp, string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(posedge clk); #1;
    drive(a, b, stop);
    grp_valid = 1'b1;
    do @(negedge clk); while (!cur_issue());
  endtask

  task automatic idle(int n);
    @(posedge clk); #1;
    grp_valid = 1'b0;
    drive('0, '0, 1'b0);
    repeat (n) @(posedge clk);
  endtask

  task automatic do_reset();
    @(posedge clk); #1;
    grp_valid = 1'b0;
    drive('0, '0, 1'b0);
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(posedge clk);
  endtask

  task automatic check(bit ok, string tag, int act, int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Monitor: count stall cycles of the presented chunk, compare on issue.
  always @(negedge clk) begin
    int    e;
    string t;
    if (rst_n && grp_valid) begin
      if (cur_issue()) begin
        n_vec++;
        if (exp_q.size() == 0) begin
          n_bad++;
          $display("FAIL unexpected issue: actual %0d expected none", cyc);
        end else begin
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          if (cyc != e) begin
            n_bad++;
            $display("FAIL %s: stall cycles actual %0d expected %0d", t, cyc, e);
          end
        end
        cyc = 0;
      end else begin
        cyc++;
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    lane_t a, b;
    rst_n = 1'b1;
    grp_valid = 1'b0;
    drive('0, '0, 1'b0);
    do_reset();

    // R9: idle inputs never issue
    @(negedge clk);
    check(!issue_fw && !issue_nf, "R9 idle", int'(issue_fw), 0);

    // R1: fresh scoreboard, any registers issue at once
    a = op(1'b1, 1, 2); a.sb = 6'd9; a.sbe = 1'b1; a.ps = 6'd3; a.pse = 1'b1;
    b = op(1'b0, 3, 4);
    apply(a, b, 1'b1, 0, "R1 reset state");

    // R2: integer chain one per cycle
    apply(op(1'b0, 9, 10),  '0, 1'b1, 0, "R2 chain head");
    apply(op(1'b0, 10, 11), '0, 1'b1, 0, "R2 dep 1");
    apply(op(1'b0, 11, 12), '0, 1'b1, 0, "R2 dep 2");
    apply(op(1'b0, 12, 13), '0, 1'b1, 0, "R2 dep 3");
    idle(6);

    // R3: floating-point chain one per four cycles
    apply(op(1'b1, 19, 20), '0, 1'b1, 0, "R3 chain head");
    apply(op(1'b1, 20, 21), '0, 1'b1, 3, "R3 dep 1");
    apply(op(1'b1, 21, 22), '0, 1'b1, 3, "R3 dep 2");
    idle(6);

    // R4: no forwarding, integer takes four cycles
    do_reset();
    use_nf = 1'b1;
    apply(op(1'b0, 29, 30), '0, 1'b1, 0, "R4 chain head");
    apply(op(1'b0, 30, 31), '0, 1'b1, 3, "R4 dep 1");
    apply(op(1'b0, 31, 32), '0, 1'b1, 3, "R4 dep 2");
    idle(6);
    use_nf = 1'b0;
    do_reset();

    // R5: open group is free, remaining countdown applies after the stop
    apply(op(1'b1, -1, 10), '0, 1'b0, 0, "R5 open write");
    apply(op(1'b0, 10, 11), '0, 1'b1, 0, "R5 same group read");
    apply(op(1'b0, 10, 12), '0, 1'b1, 2, "R5 next group read");
    idle(6);

    // R6: compare feeding a flagged branch in the same chunk
    a = '0; a.v = 1'b1; a.fp = 1'b1; a.pd = 6'd5; a.pde = 1'b1;
    apply(a, '0, 1'b1, 0, "R6 fp compare");
    a = '0; a.v = 1'b1; a.pd = 6'd5; a.pde = 1'b1;
    b = '0; b.v = 1'b1; b.br = 1'b1; b.ps = 6'd5; b.pse = 1'b1;
    apply(a, b, 1'b1, 0, "R6 branch bypass");
    idle(6);
    a = '0; a.v = 1'b1; a.fp = 1'b1; a.pd = 6'd5; a.pde = 1'b1;
    apply(a, '0, 1'b1, 0, "R6 fp compare again");
    a = '0; a.v = 1'b1; a.pd = 6'd5; a.pde = 1'b1;
    b = '0; b.v = 1'b1; b.br = 1'b0; b.ps = 6'd5; b.pse = 1'b1;
    apply(a, b, 1'b1, 3, "R6 non-branch reader waits");
    idle(6);
    a = '0; a.v = 1'b1; a.fp = 1'b1; a.pd = 6'd5; a.pde = 1'b1;
    apply(a, '0, 1'b1, 0, "R6 fp compare third");
    a = '0; a.v = 1'b1; a.br = 1'b1; a.ps = 6'd5; a.pse = 1'b1;
    apply(a, '0, 1'b1, 3, "R6 lone branch waits");
    idle(6);

    // R7: pending destination holds an overwrite
    apply(op(1'b1, -1, 7), '0, 1'b1, 0, "R7 fp write");
    apply(op(1'b0, -1, 7), '0, 1'b1, 3, "R7 overwrite");
    idle(6);

    // R8: one blocked lane holds the chunk; invalid lane ignored
    apply(op(1'b1, -1, 3), '0, 1'b1, 0, "R8 producer");
    apply(op(1'b0, 40, 41), op(1'b0, 3, 42), 1'b1, 3, "R8 lane1 blocks");
    idle(6);
    apply(op(1'b1, -1, 3), '0, 1'b1, 0, "R8 producer again");
    b = op(1'b0, 3, 42); b.v = 1'b0;
    apply(op(1'b0, 40, 41), b, 1'b1, 0, "R8 invalid lane ignored");
    idle(6);

    // R10: disabled fields ignored
    b = '0; b.v = 1'b1; b.fp = 1'b1; b.pd = 6'd6; b.pde = 1'b1;
    apply(op(1'b1, -1, 4), b, 1'b1, 0, "R10 producers");
    a = '0; a.v = 1'b1; a.sa = 6'd4; a.sb = 6'd4; a.d = 6'd4; a.ps = 6'd6;
    apply(a, '0, 1'b1, 0, "R10 disabled fields");
    idle(2);

    // R9: issue drops with grp_valid
    @(negedge clk);
    check(!issue_fw && !issue_nf, "R9 final idle", int'(issue_fw), 0);
    check(exp_q.size() == 0, "R9 queue drained", exp_q.size(), 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule